// File: doc/BRIEF.md
# Multi-Flit Request/Acknowledge Input Multiplexer

This block sits in front of one shared compute unit and funnels requests from several thread units into it. Each thread unit raises a request line and presents one flit of data on its own lane. The multiplexer acknowledges one thread unit at a time and copies the accepted flit into a buffer that holds a single flit. The buffer drives the shared unit, together with a valid bit, a last-flit flag and the index of the thread that sent the flit.

A message is a fixed number of flits. After a thread unit wins the first flit of a message, it keeps the multiplexer until its final flit has been accepted. Every other requester waits during that time. A new message goes to the next requester in round-robin order, and the search begins just after the previous owner, so no requester can be starved.

Each thread has at most one message outstanding, so results from the shared unit never meet at a thread. For that reason the return path has no arbitration. It is a single register stage that turns a destination thread index into a one-hot valid strobe and carries the result data alongside it.

Top module: `flit_input_mux`

## Requirements
- R1: After reset, ack_o, out_valid_o and ret_valid_o are all zero.
- R2: In any cycle at most one bit of ack_o is set, and a bit is set only when the matching bit of req_i is high in that same cycle.
- R3: A flit accepted in cycle t (ack bit k set) appears in cycle t+1 with out_valid_o=1, out_src_o=k and out_data_o equal to lane k of data_i at the accepting edge. A cycle with no ack gives out_valid_o=0 in the next cycle.
- R4: Once the first flit of a message from requester k has been accepted, no requester other than k receives an ack until the MSG_FLITS-th flit of that message has been accepted.
- R5: out_last_o is 1 on the MSG_FLITS-th flit of each message and 0 on every earlier flit.
- R6: If the owner of an unfinished message lowers its request, no flit is accepted, even when other requests are high. The message continues when the owner raises its request again.
- R7: A new message is granted to the first requesting index after the previous message's owner, searching in increasing index order and wrapping from NUM_REQ-1 to 0. After reset the search begins at index 0.
- R8: When res_valid_i is high in cycle t, in cycle t+1 ret_valid_o has only bit res_dst_i set and ret_data_o equals res_data_i. When res_valid_i is low, ret_valid_o is zero in the next cycle.
- R9: The flit of requester k is taken from data_i bits [k*FLIT_W +: FLIT_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_REQ | Request line per thread unit |
| data_i | input | NUM_REQ*FLIT_W | Flit lane per thread unit, lane k at k*FLIT_W |
| ack_o | output | NUM_REQ | Per-requester acknowledge: flit taken at this edge |
| out_valid_o | output | 1 | Buffer holds a flit for the shared unit |
| out_data_o | output | FLIT_W | Buffered flit |
| out_last_o | output | 1 | Buffered flit closes its message |
| out_src_o | output | ID_W | Thread index of the buffered flit |
| res_valid_i | input | 1 | Shared unit result strobe |
| res_data_i | input | RES_W | Shared unit result |
| res_dst_i | input | ID_W | Destination thread of the result |
| ret_valid_o | output | NUM_REQ | One-hot registered result strobe |
| ret_data_o | output | RES_W | Registered result data |

## Verification
A flit counter that is wrong, or an owner register that is lost, shows up at the ports within the same cycle. The owner's ack appears too early or too late, or a waiting requester is acked while a message is still open. The buffer then reports a wrong out_last_o or out_src_o one cycle later. A round-robin pointer in the wrong state shows up only at the next message boundary, as the wrong ack bit. The bench therefore runs full contention rounds so that every boundary is visible. A fault in the return stage shows up one cycle after the result strobe, as a wrong one-hot bit or wrong data.

// File: rtl/flit_mux_pkg.sv
package flit_mux_pkg;

  // Width needed to index n items, never below 1.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Next position in a circular search over n slots.
  function automatic int wrap_add(input int base, input int step, input int n);
    return (base + step) % n;
  endfunction

endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter
  import flit_mux_pkg::*;
#(
  parameter int NUM_REQ = 4,
  localparam int ID_W = idx_width(NUM_REQ)
) (
  input  logic [NUM_REQ-1:0] req,
  input  logic [ID_W-1:0]    prev_idx,
  output logic               any,
  output logic [ID_W-1:0]    win_idx
);

  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    for (int k = 1; k <= NUM_REQ; k++) begin
      int cand;
      cand = wrap_add(int'(prev_idx), k, NUM_REQ);
      if (!any && req[cand]) begin
        any     = 1'b1;
        win_idx = ID_W'(cand);
      end
    end
  end

endmodule

// File: rtl/flit_link.sv
module flit_link #(
  parameter int FLIT_W = 16,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FLIT_W-1:0] din,
  input  logic              din_last,
  input  logic [ID_W-1:0]   din_src,
  output logic              q_valid,
  output logic [FLIT_W-1:0] q_data,
  output logic              q_last,
  output logic [ID_W-1:0]   q_src
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_last  <= 1'b0;
      q_src   <= '0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_data <= din;
        q_last <= din_last;
        q_src  <= din_src;
      end
    end
  end

endmodule

// File: rtl/return_stage.sv
module return_stage #(
  parameter int NUM_REQ = 4,
  parameter int RES_W   = 32,
  parameter int ID_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [RES_W-1:0]   in_data,
  input  logic [ID_W-1:0]    in_dst,
  output logic [NUM_REQ-1:0] out_valid,
  output logic [RES_W-1:0]   out_data
);

  logic [NUM_REQ-1:0] dst_hot;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_dec
    assign dst_hot[g] = in_valid && (in_dst == ID_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= dst_hot;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/flit_input_mux.sv
module flit_input_mux
  import flit_mux_pkg::*;
#(
  parameter int NUM_REQ   = 4,
  parameter int FLIT_W    = 16,
  parameter int MSG_FLITS = 2,
  parameter int RES_W     = 32,
  localparam int ID_W     = idx_width(NUM_REQ),
  localparam int CNT_W    = idx_width(MSG_FLITS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        req_i,
  input  logic [NUM_REQ*FLIT_W-1:0] data_i,
  output logic [NUM_REQ-1:0]        ack_o,
  output logic                      out_valid_o,
  output logic [FLIT_W-1:0]         out_data_o,
  output logic                      out_last_o,
  output logic [ID_W-1:0]           out_src_o,
  input  logic                      res_valid_i,
  input  logic [RES_W-1:0]          res_data_i,
  input  logic [ID_W-1:0]           res_dst_i,
  output logic [NUM_REQ-1:0]        ret_valid_o,
  output logic [RES_W-1:0]          ret_data_o
);

  // Message ownership state
  logic             busy_q;
  logic [ID_W-1:0]  owner_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ID_W-1:0]  prev_owner_q;

  // Named internal events
  logic             arb_any;
  logic [ID_W-1:0]  arb_idx;
  logic [ID_W-1:0]  cur_idx;
  logic             accept;
  logic             flit_is_last;
  logic             msg_start;
  logic             msg_done;
  logic [FLIT_W-1:0] sel_flit;

  rr_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
    .req      (req_i),
    .prev_idx (prev_owner_q),
    .any      (arb_any),
    .win_idx  (arb_idx)
  );

  assign cur_idx      = busy_q ? owner_q : arb_idx;
  assign accept       = busy_q ? req_i[owner_q] : arb_any;
  assign flit_is_last = (cnt_q == CNT_W'(MSG_FLITS - 1));
  assign msg_start    = accept && !busy_q;
  assign msg_done     = accept && flit_is_last;
  assign sel_flit     = data_i[cur_idx*FLIT_W +: FLIT_W];
  assign ack_o        = accept ? (NUM_REQ'(1) << cur_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      owner_q      <= '0;
      cnt_q        <= '0;
      prev_owner_q <= ID_W'(NUM_REQ - 1);
    end else if (accept) begin
      if (flit_is_last) begin
        busy_q       <= 1'b0;
        cnt_q        <= '0;
        prev_owner_q <= cur_idx;
      end else begin
        busy_q  <= 1'b1;
        owner_q <= cur_idx;
        cnt_q   <= cnt_q + CNT_W'(1);
      end
    end
  end

  flit_link #(.FLIT_W(FLIT_W), .ID_W(ID_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .din      (sel_flit),
    .din_last (flit_is_last),
    .din_src  (cur_idx),
    .q_valid  (out_valid_o),
    .q_data   (out_data_o),
    .q_last   (out_last_o),
    .q_src    (out_src_o)
  );

  return_stage #(.NUM_REQ(NUM_REQ), .RES_W(RES_W), .ID_W(ID_W)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (res_valid_i),
    .in_data   (res_data_i),
    .in_dst    (res_dst_i),
    .out_valid (ret_valid_o),
    .out_data  (ret_data_o)
  );

endmodule

// File: rtl/flit_mux_chk.sv
module flit_mux_chk #(
  parameter int NUM_REQ = 4,
  parameter int ID_W    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REQ-1:0] req_i,
  input logic [NUM_REQ-1:0] ack_o,
  input logic               out_valid_o,
  input logic               out_last_o,
  input logic [ID_W-1:0]    out_src_o,
  input logic               res_valid_i,
  input logic [NUM_REQ-1:0] ret_valid_o,
  input logic               msg_start
);

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o)); // R2

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o & ~req_i) == '0); // R2

  AST_ACK_FILLS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o != '0) |=> out_valid_o); // R3

  AST_IDLE_EMPTIES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o == '0) |=> !out_valid_o); // R3

  AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_last_o) |-> ((ack_o & ~(NUM_REQ'(1) << out_src_o)) == '0)); // R4

  AST_NO_START_MIDMSG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_last_o) |-> !msg_start); // R6

  AST_RET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ret_valid_o)); // R8

  AST_RET_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_i |=> (ret_valid_o != '0)); // R8

endmodule

bind flit_input_mux flit_mux_chk #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .ack_o       (ack_o),
  .out_valid_o (out_valid_o),
  .out_last_o  (out_last_o),
  .out_src_o   (out_src_o),
  .res_valid_i (res_valid_i),
  .ret_valid_o (ret_valid_o),
  .msg_start   (msg_start)
);

// File: tb/sim_flit_input_mux.sv
module sim_flit_input_mux;

  localparam int N  = 4;
  localparam int FW = 16;
  localparam int MF = 2;
  localparam int RW = 32;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_i = '0;
  logic [N*FW-1:0] data_i = '0;
  logic [N-1:0]  ack_o;
  logic          out_valid_o;
  logic [FW-1:0] out_data_o;
  logic          out_last_o;
  logic [IW-1:0] out_src_o;
  logic          res_valid_i = 1'b0;
  logic [RW-1:0] res_data_i = '0;
  logic [IW-1:0] res_dst_i = '0;
  logic [N-1:0]  ret_valid_o;
  logic [RW-1:0] ret_data_o;

  int n_vec = 0;
  int n_bad = 0;
  int stepno = 0;

  always #2.5 clk = ~clk;

  flit_input_mux #(.NUM_REQ(N), .FLIT_W(FW), .MSG_FLITS(MF), .RES_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .data_i(data_i), .ack_o(ack_o),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_last_o(out_last_o),
    .out_src_o(out_src_o), .res_valid_i(res_valid_i), .res_data_i(res_data_i),
    .res_dst_i(res_dst_i), .ret_valid_o(ret_valid_o), .ret_data_o(ret_data_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] lane_val(input int k, input int s);
    return {4'hA, 4'(k), 8'(s)};
  endfunction

  // One cycle: drive requests, check ack before the edge, buffer after it.
  task automatic step(input logic [N-1:0] rq, input logic [N-1:0] exp_ack,
                      input bit exp_last, input string tag);
    int idx;
    @(negedge clk);
    stepno++;
    req_i = rq;
    for (int k = 0; k < N; k++) data_i[k*FW +: FW] = lane_val(k, stepno);
    #1;
    chk(ack_o == exp_ack, {tag, " ack"}, 32'(ack_o), 32'(exp_ack));
    @(posedge clk);
    #1;
    chk(out_valid_o == (exp_ack != '0), {tag, " valid R3"}, 32'(out_valid_o), 32'(exp_ack != '0));
    if (exp_ack != '0) begin
      idx = 0;
      for (int k = 0; k < N; k++) if (exp_ack[k]) idx = k;
      chk(out_data_o == lane_val(idx, stepno), {tag, " data R9"}, 32'(out_data_o), 32'(lane_val(idx, stepno)));
      chk(out_src_o == IW'(idx), {tag, " src R3"}, 32'(out_src_o), 32'(idx));
      chk(out_last_o == exp_last, {tag, " last R5"}, 32'(out_last_o), 32'(exp_last));
    end
  endtask

  task automatic t_reset();
    #1;
    chk(ack_o == '0, "R1 ack", 32'(ack_o), 0);
    chk(out_valid_o == 1'b0, "R1 out_valid", 32'(out_valid_o), 0);
    chk(ret_valid_o == '0, "R1 ret_valid", 32'(ret_valid_o), 0);
  endtask

  task automatic t_single();
    step(4'b0001, 4'b0001, 1'b0, "R7 first grant idx0");
    step(4'b0001, 4'b0001, 1'b1, "R5 second flit");
    step(4'b0000, 4'b0000, 1'b0, "R3 idle");
  endtask

  task automatic t_contend();
    step(4'b1111, 4'b0010, 1'b0, "R7 rr to 1");
    step(4'b1111, 4'b0010, 1'b1, "R4 hold 1");
    step(4'b1111, 4'b0100, 1'b0, "R7 rr to 2");
    step(4'b1111, 4'b0100, 1'b1, "R4 hold 2");
    step(4'b1111, 4'b1000, 1'b0, "R7 rr to 3");
    step(4'b1111, 4'b1000, 1'b1, "R4 hold 3");
    step(4'b1111, 4'b0001, 1'b0, "R7 wrap to 0");
    step(4'b1111, 4'b0001, 1'b1, "R4 hold 0");
  endtask

  task automatic t_stall();
    step(4'b0110, 4'b0010, 1'b0, "R7 grant 1");
    step(4'b0100, 4'b0000, 1'b0, "R6 owner dropped");
    step(4'b0100, 4'b0000, 1'b0, "R6 still stalled");
    step(4'b0110, 4'b0010, 1'b1, "R6 resume");
    step(4'b0100, 4'b0100, 1'b0, "R7 next 2");
    step(4'b0100, 4'b0100, 1'b1, "R5 finish 2");
  endtask

  task automatic t_wrap();
    step(4'b0011, 4'b0001, 1'b0, "R7 skip to 0");
    step(4'b0011, 4'b0001, 1'b1, "R4 hold 0");
    step(4'b1000, 4'b1000, 1'b0, "R7 lone 3");
    step(4'b1010, 4'b1000, 1'b1, "R4 1 waits");
    step(4'b1010, 4'b0010, 1'b0, "R7 then 1");
    step(4'b0010, 4'b0010, 1'b1, "R5 last 1");
  endtask

  task automatic t_return();
    @(negedge clk);
    req_i = '0;
    res_valid_i = 1'b1; res_dst_i = 2'd2; res_data_i = 32'hCAFE0002;
    @(posedge clk); #1;
    chk(ret_valid_o == 4'b0100, "R8 dst2 strobe", 32'(ret_valid_o), 32'h4);
    chk(ret_data_o == 32'hCAFE0002, "R8 dst2 data", ret_data_o, 32'hCAFE0002);
    @(negedge clk);
    res_dst_i = 2'd3; res_data_i = 32'h1234_5678;
    @(posedge clk); #1;
    chk(ret_valid_o == 4'b1000, "R8 dst3 strobe", 32'(ret_valid_o), 32'h8);
    chk(ret_data_o == 32'h1234_5678, "R8 dst3 data", ret_data_o, 32'h12345678);
    @(negedge clk);
    res_valid_i = 1'b0;
    @(posedge clk); #1;
    chk(ret_valid_o == '0, "R8 no strobe", 32'(ret_valid_o), 0);
  endtask

  initial begin
    t_reset();
    #12;
    @(negedge clk);
    rst_n = 1'b1;
    t_single();
    t_contend();
    t_stall();
    t_wrap();
    t_return();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule